// File: doc/BRIEF.md
# Multichannel I2S Serializer

This block sits in the audio master clock domain. It turns parallel left/right sample pairs for several audio channels into I2S serial streams. A single generator produces the bit clock and the word select, and every channel drives its own serial data line. The master clock runs at 18.432 MHz. A two-bit rate select picks a bit-clock divider of 8, 4 or 2. With 48 bit clocks per frame, this gives frame rates of exactly 48, 96 or 192 kHz.

A one-cycle load strobe, already synchronized into this clock domain, offers a new set of samples. The samples are held and copied into the per-channel shifters only when a new frame begins. If no strobe has arrived since the last boundary, the previous samples are sent again. An enable input starts and stops the output. While the enable is low, every output is quiet, and each new start begins with a left word.

Top module: `i2s_serializer_mc`

## Requirements
- R1: `rst` is synchronous and active high. It clears the held samples and drives `sck_out`, `ws_out` and every `sd_out` bit low.
- R2: `rate_sel` sets the bit-clock divider as follows:
  - 2'b00 divides the master clock by 8.
  - 2'b01 divides it by 4.
  - 2'b11 divides it by 2.
  - 2'b10 behaves like 2'b00.
  
  High and low phases of `sck_out` are equal: 4, 2 or 1 master cycles.
- R3: On the first clock edge where `enable` is sampled high after being low, bit slot 0 starts with `sck_out` low. Every slot lasts one full bit-clock period, and a frame has 48 slots.
- R4: `ws_out` is high in slots 23 to 46 and low in slots 47 and 0 to 22. So `ws_out` leads each word by one bit clock, low for left and high for right. It changes only together with a falling edge of `sck_out`.
- R5: `sd_out` sends the left sample MSB first in slots 0 to 23, then the right sample MSB first in slots 24 to 47. It changes only together with a falling edge of `sck_out`.
- R6: A `load_stb` pulse captures `left_in`/`right_in` into a holding register. That register is copied to the shifters only at the start of a frame. If no pulse arrives, the previous samples repeat in the next frame.
- R7: When `load_stb` falls in the same cycle as the start of a frame, the samples offered with it are the ones sent in that frame.
- R8: When `enable` is sampled low, `sck_out`, `ws_out` and all `sd_out` bits are low from the next cycle on. The slot counter resets, so the next start begins at slot 0 with a left word.
- R9: All channels share `sck_out` and `ws_out`. Channel k takes its samples from bits [24k+23:24k] of `left_in` and `right_in` and drives `sd_out[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Output run enable |
| rate_sel | input | 2 | Frame rate code (00 48 kHz, 01 96 kHz, 11 192 kHz) |
| load_stb | input | 1 | One-cycle strobe offering a new sample set |
| left_in | input | NUM_CH*SAMPLE_W | Left samples, channel k in slice k |
| right_in | input | NUM_CH*SAMPLE_W | Right samples, channel k in slice k |
| sck_out | output | 1 | Serial bit clock |
| ws_out | output | 1 | Word select (low = left) |
| sd_out | output | NUM_CH | Serial data, one line per channel |

## Verification
Two events can land on the same master clock edge: a load strobe and the frame boundary that copies the held samples into the shifters. The bench provokes this by tracking elapsed cycles in its own model and firing the strobe exactly at the boundary edge, at two different rates. It then judges every transmitted bit of the following frame against the new samples. Strobes in the middle of a frame, and frames with no strobe, are compared in the same way. These show that the old samples finish their frame and then repeat.

// File: rtl/i2s_ser_pkg.sv
package i2s_ser_pkg;

  typedef enum logic [1:0] {
    RATE_48K  = 2'b00,
    RATE_96K  = 2'b01,
    RATE_RSVD = 2'b10,
    RATE_192K = 2'b11
  } rate_e;

  localparam int HALF_W = 3;

  // master cycles spent in each half of one bit-clock period
  function automatic logic [HALF_W-1:0] half_period(input logic [1:0] sel);
    case (rate_e'(sel))
      RATE_96K:  return 3'd2;
      RATE_192K: return 3'd1;
      default:   return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/i2s_clk_seq.sv
module i2s_clk_seq
  import i2s_ser_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic [1:0] rate_sel,
  output logic       sck,
  output logic       ws,
  output logic       frame_load,
  output logic       shift_en
);

  localparam int FRAME  = 2 * WORD_W;
  localparam int SLOT_W = $clog2(FRAME);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME - 1);
  localparam logic [SLOT_W-1:0] WS_HI     = SLOT_W'(WORD_W - 1);

  logic              run_q;
  logic [HALF_W-1:0] div_q;
  logic [SLOT_W-1:0] slot_q;
  logic              sck_q;
  logic              ws_q;

  logic [HALF_W-1:0] half;
  logic              tick;
  logic              fall_ev;
  logic              wrap;
  logic              start;
  logic [SLOT_W-1:0] slot_nx;

  assign half    = half_period(rate_sel);
  assign tick    = (div_q >= half - 3'd1);
  assign fall_ev = run_q && tick && sck_q;
  assign wrap    = fall_ev && (slot_q == LAST_SLOT);
  assign start   = enable && !run_q;
  assign slot_nx = wrap ? '0 : slot_q + 1'b1;

  assign frame_load = enable && (start || wrap);
  assign shift_en   = enable && fall_ev && !wrap;

  function automatic logic ws_of(input logic [SLOT_W-1:0] s);
    return (s >= WS_HI) && (s < LAST_SLOT);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      run_q  <= 1'b0;
      div_q  <= '0;
      slot_q <= '0;
      sck_q  <= 1'b0;
      ws_q   <= 1'b0;
    end else if (start) begin
      run_q  <= 1'b1;
      div_q  <= '0;
      slot_q <= '0;
      sck_q  <= 1'b0;
      ws_q   <= ws_of('0);
    end else if (tick) begin
      div_q <= '0;
      sck_q <= ~sck_q;
      if (sck_q) begin
        slot_q <= slot_nx;
        ws_q   <= ws_of(slot_nx);
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign sck = sck_q;
  assign ws  = ws_q;

endmodule

// File: rtl/i2s_lane.sv
module i2s_lane #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load_stb,
  input  logic [WORD_W-1:0] left,
  input  logic [WORD_W-1:0] right,
  input  logic              frame_load,
  input  logic              shift_en,
  output logic              sd
);

  localparam int FRAME = 2 * WORD_W;

  logic [WORD_W-1:0] hold_l;
  logic [WORD_W-1:0] hold_r;
  logic [FRAME-1:0]  shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_l <= '0;
      hold_r <= '0;
    end else if (load_stb) begin
      hold_l <= left;
      hold_r <= right;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      shreg <= '0;
    end else if (frame_load) begin
      shreg <= load_stb ? {left, right} : {hold_l, hold_r};
    end else if (shift_en) begin
      shreg <= {shreg[FRAME-2:0], 1'b0};
    end
  end

  assign sd = shreg[FRAME-1];

endmodule

// File: rtl/i2s_serializer_mc.sv
module i2s_serializer_mc #(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 24
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         enable,
  input  logic [1:0]                   rate_sel,
  input  logic                         load_stb,
  input  logic [NUM_CH*SAMPLE_W-1:0]   left_in,
  input  logic [NUM_CH*SAMPLE_W-1:0]   right_in,
  output logic                         sck_out,
  output logic                         ws_out,
  output logic [NUM_CH-1:0]            sd_out
);

  logic frame_load;
  logic shift_en;

  i2s_clk_seq #(.WORD_W(SAMPLE_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .rate_sel   (rate_sel),
    .sck        (sck_out),
    .ws         (ws_out),
    .frame_load (frame_load),
    .shift_en   (shift_en)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
    i2s_lane #(.WORD_W(SAMPLE_W)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .clr        (!enable),
      .load_stb   (load_stb),
      .left       (left_in[k*SAMPLE_W +: SAMPLE_W]),
      .right      (right_in[k*SAMPLE_W +: SAMPLE_W]),
      .frame_load (frame_load),
      .shift_en   (shift_en),
      .sd         (sd_out[k])
    );
  end

endmodule

// File: rtl/i2s_serializer_mc_chk.sv
module i2s_serializer_mc_chk
  import i2s_ser_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [1:0]        rate_sel,
  input logic              sck_out,
  input logic              ws_out,
  input logic [NUM_CH-1:0] sd_out
);

  localparam int CW = $clog2(SAMPLE_W + 1) + 1;

  logic          sck_q, ws_q;
  logic          sck_seen, ws_seen;
  logic [7:0]    sck_cnt;
  logic [CW-1:0] fall_cnt;
  logic          sck_tog, ws_tog, fall_now;
  logic [HALF_W-1:0] half;

  assign sck_tog  = sck_out != sck_q;
  assign ws_tog   = ws_out != ws_q;
  assign fall_now = sck_q && !sck_out;
  assign half     = half_period(rate_sel);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      sck_q    <= 1'b0;
      ws_q     <= 1'b0;
      sck_seen <= 1'b0;
      ws_seen  <= 1'b0;
      sck_cnt  <= '0;
      fall_cnt <= '0;
    end else begin
      sck_q <= sck_out;
      ws_q  <= ws_out;
      if (sck_tog) begin
        sck_cnt  <= '0;
        sck_seen <= 1'b1;
      end else begin
        sck_cnt <= sck_cnt + 1'b1;
      end
      if (ws_tog) begin
        fall_cnt <= '0;
        ws_seen  <= 1'b1;
      end else if (fall_now) begin
        fall_cnt <= fall_cnt + 1'b1;
      end
    end
  end

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!sck_out && !ws_out && sd_out == '0)); // R8

  AST_DATA_STEADY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_out) |-> ($stable(sd_out) && $stable(ws_out))); // R5

  AST_WS_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    ($past(enable) && !$stable(ws_out)) |-> $fell(sck_out)); // R4

  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (enable && sck_seen && sck_tog) |-> (sck_cnt == 8'(half) - 8'd1)); // R2

  AST_WORD_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (enable && ws_seen && ws_tog) |-> (fall_cnt == CW'(SAMPLE_W - 1))); // R3

endmodule

bind i2s_serializer_mc i2s_serializer_mc_chk #(
  .NUM_CH   (NUM_CH),
  .SAMPLE_W (SAMPLE_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .rate_sel (rate_sel),
  .sck_out  (sck_out),
  .ws_out   (ws_out),
  .sd_out   (sd_out)
);

// File: tb/i2s_serializer_mc_tb.sv
module i2s_serializer_mc_tb;

  localparam int NCH = 4;
  localparam int W   = 24;

  logic             clk = 1'b0;
  logic             rst, enable, load_stb;
  logic [1:0]       rate_sel;
  logic [NCH*W-1:0] left_in, right_in;
  logic             sck_out, ws_out;
  logic [NCH-1:0]   sd_out;

  int n_checks = 0;
  int n_fails  = 0;
  string focus = "R1";

  always #2.5 clk = ~clk;

  i2s_serializer_mc #(.NUM_CH(NCH), .SAMPLE_W(W)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .rate_sel(rate_sel),
    .load_stb(load_stb), .left_in(left_in), .right_in(right_in),
    .sck_out(sck_out), .ws_out(ws_out), .sd_out(sd_out)
  );

  // behavioural reference: time since start decides everything
  logic [W-1:0]   pend_l [NCH], pend_r [NCH], cur_l [NCH], cur_r [NCH];
  bit             m_run;
  int             m_t, m_h;
  logic           e_sck, e_ws;
  logic [NCH-1:0] e_sd;

  function automatic int half_of(logic [1:0] s);
    if (s == 2'b01) return 2;
    if (s == 2'b11) return 1;
    return 4;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_t = 0;
      for (int k = 0; k < NCH; k++) begin
        pend_l[k] = '0; pend_r[k] = '0; cur_l[k] = '0; cur_r[k] = '0;
      end
      e_sck = 0; e_ws = 0; e_sd = '0;
    end else if (!enable) begin
      m_run = 0; m_t = 0;
      e_sck = 0; e_ws = 0; e_sd = '0;
      if (load_stb)
        for (int k = 0; k < NCH; k++) begin
          pend_l[k] = left_in[k*W +: W]; pend_r[k] = right_in[k*W +: W];
        end
    end else begin
      int slot;
      if (!m_run) begin m_run = 1; m_t = 0; end
      else m_t++;
      m_h = half_of(rate_sel);
      if (m_t % (96 * m_h) == 0)
        for (int k = 0; k < NCH; k++) begin
          cur_l[k] = load_stb ? left_in[k*W +: W]  : pend_l[k];
          cur_r[k] = load_stb ? right_in[k*W +: W] : pend_r[k];
        end
      if (load_stb)
        for (int k = 0; k < NCH; k++) begin
          pend_l[k] = left_in[k*W +: W]; pend_r[k] = right_in[k*W +: W];
        end
      slot  = (m_t / (2 * m_h)) % 48;
      e_sck = (m_t % (2 * m_h)) >= m_h;
      e_ws  = (slot >= 23) && (slot < 47);
      for (int k = 0; k < NCH; k++)
        e_sd[k] = (slot < 24) ? cur_l[k][23 - slot] : cur_r[k][47 - slot];
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s (focus %s) t=%0d: actual %h expected %h", tag, focus, m_t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(enable || m_run ? "R3 sck" : "R8 sck", 64'(sck_out), 64'(e_sck));
      chk(enable || m_run ? "R4 ws" : "R8 ws", 64'(ws_out), 64'(e_ws));
      chk("R5 R9 sd", 64'(sd_out), 64'(e_sd));
    end
  end

  task automatic pulse_load(int seed);
    for (int k = 0; k < NCH; k++) begin
      left_in[k*W +: W]  = 24'(seed * 32'h0013579B + k * 32'h000F0F1) ^ 24'hA5A5A5;
      right_in[k*W +: W] = 24'(seed * 32'h002468AD + k * 32'h0031337) ^ 24'h5A3C96;
    end
    load_stb = 1'b1;
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic wait_t(int target);
    while (!(m_run && m_t == target)) @(negedge clk);
  endtask

  initial begin
    rst = 1; enable = 0; load_stb = 0; rate_sel = 2'b00;
    left_in = '0; right_in = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset outputs", {61'd0, sck_out, ws_out, |sd_out}, 64'd0);

    focus = "R6";
    pulse_load(1);
    rate_sel = 2'b00; enable = 1;
    wait_t(500);
    pulse_load(2);                 // mid-frame: old set finishes first
    wait_t(1000);

    focus = "R8";
    enable = 0;
    repeat (5) @(negedge clk);
    chk("R8 quiet while off", {61'd0, sck_out, ws_out, |sd_out}, 64'd0);

    focus = "R7";
    rate_sel = 2'b01; enable = 1;
    wait_t(96 * 2 - 1);
    pulse_load(3);                 // strobe on the boundary edge
    wait_t(96 * 2 * 3 - 1);
    pulse_load(4);
    wait_t(96 * 2 * 4 + 50);

    focus = "R8";
    enable = 0;                    // stop mid-frame, restart with left word
    repeat (3) @(negedge clk);
    focus = "R2";
    rate_sel = 2'b11; enable = 1;
    wait_t(95);
    pulse_load(5);
    wait_t(96 * 3 + 10);

    enable = 0;
    repeat (2) @(negedge clk);
    rate_sel = 2'b10; enable = 1;  // reserved code behaves like 48 kHz
    pulse_load(6);
    wait_t(96 * 4 + 20);
    enable = 0;
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule